// File: doc/BRIEF.md
# Strobed Parallel Port Pair with Interrupt Unit

This block provides two byte-wide general-purpose parallel ports, called A and B, and one interrupt status unit. All of them sit on a simple synchronous register bus. Each port can be an input port or an output port. The whole port takes one direction.

An input port holds a data register that is clocked by the strobe input XOR a software polarity bit. While that clock is low the register follows the pins. Its rising edge, which is the trailing edge of the strobe, freezes the register and raises the port's interrupt flag. Because the polarity bit is part of that clock, software can flip the bit to capture the pins and raise an interrupt with no strobe activity at all.

An output port drives the written byte onto its pins, either push-pull or open-drain. Each write to the port's data register also emits a fixed-width pulse on the port's strobe pin.

The interrupt unit gathers the two port flags and an end-of-write flag into one active-low request. A mode bit selects how the port flags are cleared:
- by reading the port data register, or
- by writing zero to the flag's bit in the status register.

The end-of-write flag is set by a one-cycle pulse from a neighbouring programming engine. Software clears it by writing zero to its bit.

Bus accesses take one cycle each. Read data is registered and appears on the cycle after the read strobe. The register addresses are:

| Address | Register |
|---|---|
| 0 | port A data |
| 1 | port B data |
| 2 | port A pins |
| 3 | port B pins |
| 4 | status |
| 5 | configuration |

Top module: `pio_pair`

## Requirements
- R1: After reset, status (address 4) reads 0x00 and configuration (address 5) reads 0x40, because bit 6 of configuration always reads 1. After reset, irq_n is 1 and no pin or strobe output is enabled.
- R2: The configuration bits are: bit 7 clear mode, bit 5 open-drain A, bit 4 open-drain B, bit 3 direction A, bit 2 direction B (1 = output), bit 1 polarity A, bit 0 polarity B. For an input port, while (synchronised strobe XOR polarity) is 0, reading the port data register returns the current pin values.
- R3: For an input port, a 0-to-1 transition of (strobe XOR polarity) captures the pins into the data register and holds them there. The same transition sets the port flag (status bit 6 for A, bit 5 for B) and the summary flag (status bit 7). The summary flag is the OR of the two port flags.
- R4: With the strobe held steady, a configuration write that moves the polarity bit from 1 to 0, while the strobe is high, captures the pins and sets the port and summary flags. This is the software-generated interrupt.
- R5: An output port never sets its flag, whatever its strobe input does. Each write to its data register emits a strobe pulse of PULSE_W cycles (default 4). The pulse is at the polarity bit's level; between pulses the strobe sits at the inverse level.
- R6: An output port in push-pull mode drives pin_o with the data and enables all pins. In open-drain mode it drives pin_o to 0 and enables only the pins whose data bit is 0.
- R7: With clear mode 0, reading a port's data register clears that port's flag. In this mode, writing the status register leaves the flags unchanged.
- R8: With clear mode 1, reading the data register leaves the flags set. Writing 0 to a flag bit in status clears that flag; writing 1 to a flag bit never sets it.
- R9: irq_n goes to 0 when any flag is set together with its enable: enable A is bit 4, enable B is bit 3, enable end-of-write is bit 2. This includes an enable written while its flag is already pending. irq_n returns to 1 once the flags are cleared.
- R10: An eow_pulse sets status bit 0. This flag raises a request only when bit 2 is set, and writing 0 to bit 0 clears it.
- R11: The pin registers (address 2 for A, address 3 for B) return the live synchronised pin inputs, whether the port is an input or an output.
- R12: A write to the data register of an input port is ignored. It produces no strobe pulse and leaves the latched value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_addr | input | 3 | register address |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, valid the cycle after bus_rd |
| eow_pulse | input | 1 | end-of-programming event, one cycle |
| a_pin_i | input | PW | port A pin inputs |
| a_pin_o | output | PW | port A pin output values |
| a_pin_oe | output | PW | port A per-pin output enables |
| a_stb_i | input | 1 | port A strobe input |
| a_stb_o | output | 1 | port A strobe output |
| a_stb_oe | output | 1 | port A strobe output enable |
| b_pin_i | input | PW | port B pin inputs |
| b_pin_o | output | PW | port B pin output values |
| b_pin_oe | output | PW | port B per-pin output enables |
| b_stb_i | input | 1 | port B strobe input |
| b_stb_o | output | 1 | port B strobe output |
| b_stb_oe | output | 1 | port B strobe output enable |
| irq_n | output | 1 | active-low interrupt request |

## Verification
The bench goes after the following corner cases, each paired with the wrong behaviour it would catch:
- The transparent phase against the frozen phase of the input latch. A latch that captured on the leading edge of the strobe would return stale pins.
- The polarity-only capture. A design that ignored the polarity bit in the latch clock would show no flag.
- An enable written after its flag is already pending. A design that looked only at new flag events would leave irq_n high.
- Both clear modes with both clearing actions. A design that cleared flags on a status write of 1, or cleared them on a read in the wrong mode, would show the wrong status value.
- An output port that is strobed externally, and a write to an input port's data register. A design that flagged the external strobe, or pulsed on the input-port write, would show a flag or a pulse where there should be none.
- The pulse width, counted cycle by cycle, and the open-drain enables.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int RW = 8;  // register width on the bus
  localparam int AW = 3;  // register address width

  typedef enum logic [AW-1:0] {
    RA_DATA_A = 3'd0,
    RA_DATA_B = 3'd1,
    RA_PINS_A = 3'd2,
    RA_PINS_B = 3'd3,
    RA_STAT   = 3'd4,
    RA_CFG    = 3'd5
  } reg_addr_e;

  // configuration field positions
  localparam int CF_CLR   = 7;
  localparam int CF_ONE   = 6;
  localparam int CF_OD_A  = 5;
  localparam int CF_DIR_A = 3;
  localparam int CF_POL_A = 1;

  // status field positions
  localparam int SF_SUM = 7;
  localparam int SF_FA  = 6;
  localparam int SF_FB  = 5;
  localparam int SF_EA  = 4;
  localparam int SF_EB  = 3;
  localparam int SF_EE  = 2;
  localparam int SF_EOW = 0;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= {W{RST_VAL}};
      s2 <= {W{RST_VAL}};
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int PW      = 8,
  parameter int PULSE_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pin_i,
  input  logic          stb_i,
  input  logic          dir,
  input  logic          od,
  input  logic          pol,
  input  logic          wr_stb,
  input  logic [PW-1:0] wr_val,
  output logic [PW-1:0] data_o,
  output logic [PW-1:0] pins_o,
  output logic          cap_ev_o,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe_o,
  output logic          stb_o,
  output logic          stb_oe_o
);
  localparam int CW = $clog2(PULSE_W + 1);

  logic [PW-1:0] pins_s;
  logic          stb_s;
  logic          lclk, lclk_q, rise;
  logic [PW-1:0] data_q;
  logic [CW-1:0] cnt_q;

  pio_sync #(.W(PW), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_i), .q(pins_s)
  );

  pio_sync #(.W(1), .RST_VAL(1'b1)) u_stb_sync (
    .clk(clk), .rst(rst), .d(stb_i), .q(stb_s)
  );

  assign lclk = stb_s ^ pol;
  assign rise = lclk & ~lclk_q;

  always_ff @(posedge clk) begin
    if (rst) lclk_q <= 1'b1;
    else     lclk_q <= lclk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (dir) begin
      if (wr_stb) data_q <= wr_val;
    end else if (!lclk || rise) begin
      data_q <= pins_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (dir && wr_stb)  cnt_q <= CW'(PULSE_W);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cap_ev_o = rise & ~dir;
  assign data_o   = data_q;
  assign pins_o   = pins_s;
  assign pin_o    = od ? '0 : data_q;
  assign pin_oe_o = dir ? (od ? ~data_q : '1) : '0;
  assign stb_o    = (cnt_q != '0) ? pol : ~pol;
  assign stb_oe_o = dir;
endmodule

// File: rtl/pio_irq.sv
module pio_irq
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_a,
  input  logic          ev_b,
  input  logic          eow_i,
  input  logic          clr_mode,
  input  logic          rd_a,
  input  logic          rd_b,
  input  logic          st_wr,
  input  logic [RW-1:0] st_wdata,
  output logic [RW-1:0] status_o,
  output logic          irq_n_o
);
  logic fa_q, fb_q, feow_q, ea_q, eb_q, ee_q, sum_q, irq_n_q;
  logic clr_a, clr_b, clr_eow, nxt_fa, nxt_fb;

  always_comb begin
    clr_a   = clr_mode ? (st_wr && !st_wdata[SF_FA]) : rd_a;
    clr_b   = clr_mode ? (st_wr && !st_wdata[SF_FB]) : rd_b;
    clr_eow = st_wr && !st_wdata[SF_EOW];
    nxt_fa  = ev_a | (fa_q & ~clr_a);
    nxt_fb  = ev_b | (fb_q & ~clr_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fa_q    <= 1'b0;
      fb_q    <= 1'b0;
      feow_q  <= 1'b0;
      ea_q    <= 1'b0;
      eb_q    <= 1'b0;
      ee_q    <= 1'b0;
      sum_q   <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      fa_q   <= nxt_fa;
      fb_q   <= nxt_fb;
      sum_q  <= nxt_fa | nxt_fb;
      feow_q <= eow_i | (feow_q & ~clr_eow);
      if (st_wr) begin
        ea_q <= st_wdata[SF_EA];
        eb_q <= st_wdata[SF_EB];
        ee_q <= st_wdata[SF_EE];
      end
      irq_n_q <= ~((fa_q & ea_q) | (fb_q & eb_q) | (feow_q & ee_q));
    end
  end

  assign status_o = {sum_q, fa_q, fb_q, ea_q, eb_q, ee_q, 1'b0, feow_q};
  assign irq_n_o  = irq_n_q;
endmodule

// File: rtl/pio_pair.sv
module pio_pair
  import pio_pkg::*;
#(
  parameter int PW      = 8,
  parameter int PULSE_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          eow_pulse,
  input  logic [PW-1:0] a_pin_i,
  output logic [PW-1:0] a_pin_o,
  output logic [PW-1:0] a_pin_oe,
  input  logic          a_stb_i,
  output logic          a_stb_o,
  output logic          a_stb_oe,
  input  logic [PW-1:0] b_pin_i,
  output logic [PW-1:0] b_pin_o,
  output logic [PW-1:0] b_pin_oe,
  input  logic          b_stb_i,
  output logic          b_stb_o,
  output logic          b_stb_oe,
  output logic          irq_n
);
  localparam int NP = 2;

  logic [RW-1:0] cfg_q, stat_w, rdata_q, rd_mux;
  logic [PW-1:0] pin_i_v [NP];
  logic [PW-1:0] pin_o_v [NP];
  logic [PW-1:0] pin_oe_v[NP];
  logic [PW-1:0] data_v  [NP];
  logic [PW-1:0] pins_v  [NP];
  logic [NP-1:0] stb_i_v, stb_o_v, stb_oe_v, cap_v, rd_dat_v;

  assign pin_i_v[0] = a_pin_i;
  assign pin_i_v[1] = b_pin_i;
  assign stb_i_v    = {b_stb_i, a_stb_i};

  always_ff @(posedge clk) begin
    if (rst)                                  cfg_q <= 8'h40;
    else if (bus_wr && bus_addr == RA_CFG)    cfg_q <= bus_wdata | (8'h1 << CF_ONE);
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic wr_p;
    assign wr_p        = bus_wr && (bus_addr == AW'(p));
    assign rd_dat_v[p] = bus_rd && (bus_addr == AW'(p));

    pio_port #(.PW(PW), .PULSE_W(PULSE_W)) u_port (
      .clk      (clk),
      .rst      (rst),
      .pin_i    (pin_i_v[p]),
      .stb_i    (stb_i_v[p]),
      .dir      (cfg_q[CF_DIR_A - p]),
      .od       (cfg_q[CF_OD_A - p]),
      .pol      (cfg_q[CF_POL_A - p]),
      .wr_stb   (wr_p),
      .wr_val   (bus_wdata[PW-1:0]),
      .data_o   (data_v[p]),
      .pins_o   (pins_v[p]),
      .cap_ev_o (cap_v[p]),
      .pin_o    (pin_o_v[p]),
      .pin_oe_o (pin_oe_v[p]),
      .stb_o    (stb_o_v[p]),
      .stb_oe_o (stb_oe_v[p])
    );
  end

  pio_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .ev_a     (cap_v[0]),
    .ev_b     (cap_v[1]),
    .eow_i    (eow_pulse),
    .clr_mode (cfg_q[CF_CLR]),
    .rd_a     (rd_dat_v[0]),
    .rd_b     (rd_dat_v[1]),
    .st_wr    (bus_wr && bus_addr == RA_STAT),
    .st_wdata (bus_wdata),
    .status_o (stat_w),
    .irq_n_o  (irq_n)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      RA_DATA_A: rd_mux[PW-1:0] = data_v[0];
      RA_DATA_B: rd_mux[PW-1:0] = data_v[1];
      RA_PINS_A: rd_mux[PW-1:0] = pins_v[0];
      RA_PINS_B: rd_mux[PW-1:0] = pins_v[1];
      RA_STAT:   rd_mux = stat_w;
      RA_CFG:    rd_mux = cfg_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign a_pin_o   = pin_o_v[0];
  assign a_pin_oe  = pin_oe_v[0];
  assign a_stb_o   = stb_o_v[0];
  assign a_stb_oe  = stb_oe_v[0];
  assign b_pin_o   = pin_o_v[1];
  assign b_pin_oe  = pin_oe_v[1];
  assign b_stb_o   = stb_o_v[1];
  assign b_stb_oe  = stb_oe_v[1];
endmodule

// File: rtl/pio_pair_chk.sv
module pio_pair_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    cfg,
  input logic [7:0]    stat,
  input logic          irq_n,
  input logic [PW-1:0] a_pin_o,
  input logic          a_stb_o,
  input logic          eow_pulse,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [2:0]    bus_addr
);
  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past((stat[6] & stat[4]) | (stat[5] & stat[3]) | (stat[0] & stat[2])));

  // R5
  out_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[6]) |-> !$past(cfg[3]));

  // R5
  pulse_level_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd0 && cfg[3]) |=> (a_stb_o == cfg[1]));

  // R6
  od_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg[5] && cfg[3]) |-> (a_pin_o == '0));

  // R8
  mode1_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg[7] && bus_rd && bus_addr == 3'd0 && stat[6] && !bus_wr) |=> stat[6]);

  // R10
  eow_set_chk: assert property (@(posedge clk) disable iff (rst)
    eow_pulse |=> stat[0]);
endmodule

bind pio_pair pio_pair_chk #(.PW(PW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cfg       (cfg_q),
  .stat      (stat_w),
  .irq_n     (irq_n),
  .a_pin_o   (a_pin_o),
  .a_stb_o   (a_stb_o),
  .eow_pulse (eow_pulse),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr)
);

// File: tb/pio_pair_tb.sv
module pio_pair_tb_top;
  localparam int PW      = 8;
  localparam int PULSE_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]    bus_addr  = '0;
  logic          bus_wr    = 1'b0;
  logic          bus_rd    = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          eow_pulse = 1'b0;
  logic [PW-1:0] a_pin_i   = '0;
  logic [PW-1:0] b_pin_i   = '0;
  logic [PW-1:0] a_pin_o, a_pin_oe, b_pin_o, b_pin_oe;
  logic          a_stb_i   = 1'b1;
  logic          b_stb_i   = 1'b1;
  logic          a_stb_o, a_stb_oe, b_stb_o, b_stb_oe, irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pio_pair #(.PW(PW), .PULSE_W(PULSE_W)) dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    brd(3'd4, v); chk("R1 status", v, 8'h00);
    brd(3'd5, v); chk("R1 config", v, 8'h40);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 a_pin_oe", a_pin_oe, 8'h00);
    chk("R1 stb_oe", {6'd0, a_stb_oe, b_stb_oe}, 8'h00);
  endtask

  task automatic t_capture;
    logic [7:0] v;
    a_pin_i = 8'h5A; a_stb_i = 1'b0; idle(6);
    brd(3'd0, v); chk("R2 transparent", v, 8'h5A);
    a_pin_i = 8'h3C; idle(6);
    a_stb_i = 1'b1; idle(6);
    a_pin_i = 8'hFF; idle(6);
    brd(3'd4, v); chk("R3 flags A", v, 8'hC0);
    brd(3'd0, v); chk("R3 held", v, 8'h3C);
    brd(3'd4, v); chk("R7 read clears", v, 8'h00);
    b_pin_i = 8'h81; b_stb_i = 1'b0; idle(6);
    b_stb_i = 1'b1; idle(6);
    brd(3'd4, v); chk("R3 flags B", v, 8'hA0);
    brd(3'd1, v); chk("R3 data B", v, 8'h81);
    brd(3'd4, v); chk("R7 read clears B", v, 8'h00);
  endtask

  task automatic t_soft_irq;
    logic [7:0] v;
    a_pin_i = 8'h77; idle(6);
    bwr(3'd5, 8'h42); idle(3);
    brd(3'd4, v); chk("R4 no flag on 0->1", v, 8'h00);
    bwr(3'd5, 8'h40); idle(3);
    brd(3'd4, v); chk("R4 soft flag", v, 8'hC0);
    chk("R9 masked", {7'd0, irq_n}, 8'h01);
    bwr(3'd4, 8'h10); idle(3);
    chk("R9 late enable", {7'd0, irq_n}, 8'h00);
    brd(3'd4, v); chk("R7 write ignored", v, 8'hD0);
    brd(3'd0, v); chk("R4 data", v, 8'h77);
    idle(3);
    chk("R9 released", {7'd0, irq_n}, 8'h01);
    brd(3'd4, v); chk("R7 cleared", v, 8'h10);
    bwr(3'd4, 8'h00);
  endtask

  task automatic t_mode1;
    logic [7:0] v;
    bwr(3'd5, 8'h80);
    brd(3'd5, v); chk("R1 const bit", v, 8'hC0);
    b_pin_i = 8'h22; b_stb_i = 1'b0; idle(6);
    b_stb_i = 1'b1; idle(6);
    brd(3'd1, v); chk("R8 data", v, 8'h22);
    brd(3'd4, v); chk("R8 read keeps", v, 8'hA0);
    bwr(3'd4, 8'hE0);
    brd(3'd4, v); chk("R8 one no set", v, 8'hA0);
    bwr(3'd4, 8'h00);
    brd(3'd4, v); chk("R8 zero clears", v, 8'h00);
    bwr(3'd5, 8'h40);
  endtask

  task automatic t_output;
    logic [7:0] v;
    int cnt;
    a_pin_i = 8'h3C;
    bwr(3'd5, 8'h48); idle(1);
    chk("R5 stb idle", {6'd0, a_stb_oe, a_stb_o}, 8'h03);
    bwr(3'd0, 8'h96);
    cnt = 0;
    while (a_stb_o == 1'b0 && cnt < 20) begin
      cnt++;
      @(negedge clk);
    end
    chk("R5 pulse width", 8'(cnt), 8'(PULSE_W));
    chk("R6 push-pull out", a_pin_o, 8'h96);
    chk("R6 push-pull oe", a_pin_oe, 8'hFF);
    brd(3'd2, v); chk("R11 pins in output", v, 8'h3C);
    a_stb_i = 1'b0; idle(6);
    a_stb_i = 1'b1; idle(6);
    brd(3'd4, v); chk("R5 no flag", v, 8'h00);
    bwr(3'd5, 8'h68); idle(1);
    chk("R6 od out", a_pin_o, 8'h00);
    chk("R6 od oe", a_pin_oe, 8'h69);
    bwr(3'd5, 8'h6A); idle(1);
    chk("R5 idle high pol", {7'd0, a_stb_o}, 8'h00);
    bwr(3'd0, 8'h0F);
    chk("R5 active high", {7'd0, a_stb_o}, 8'h01);
    idle(6);
    bwr(3'd5, 8'h68); idle(3);
    bwr(3'd5, 8'h40); idle(3);
    brd(3'd4, v); chk("R5 no spurious", v, 8'h00);
    bwr(3'd0, 8'h11);
    chk("R12 no pulse", {6'd0, a_stb_oe, a_stb_o}, 8'h01);
    brd(3'd0, v); chk("R12 ignored", v, 8'h0F);
    a_pin_i = 8'hA5; idle(4);
    brd(3'd2, v); chk("R11 pins in input", v, 8'hA5);
  endtask

  task automatic t_eow;
    logic [7:0] v;
    @(negedge clk); eow_pulse = 1'b1;
    @(negedge clk); eow_pulse = 1'b0;
    idle(2);
    brd(3'd4, v); chk("R10 set", v, 8'h01);
    chk("R10 masked", {7'd0, irq_n}, 8'h01);
    bwr(3'd4, 8'h05); idle(2);
    chk("R10 irq", {7'd0, irq_n}, 8'h00);
    bwr(3'd4, 8'h04); idle(2);
    chk("R10 cleared irq", {7'd0, irq_n}, 8'h01);
    brd(3'd4, v); chk("R10 cleared", v, 8'h04);
    bwr(3'd4, 8'h00);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(4);
    t_reset();
    t_capture();
    t_soft_irq();
    t_mode1();
    t_output();
    t_eow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule